// File: doc/BRIEF.md
# Serial Flash Command Shifter

This block runs one arbitrary transaction on a single-bit SPI bus toward a serial flash device. Software fills a bank of six transmit byte registers, writes a bit total into a count register and then writes a start code into a command register. The engine selects the device, clocks the opcode and any transmit bytes out MSB first, and shifts the device's reply into a bank of capture registers. When the last bit has been clocked, the command register reads back as zero again.

Besides the generic transfer, two fixed shortcuts exist: one reads the device status byte into a dedicated result register, the other writes one status byte. Until a key value is written to the enable register, every start code is ignored.

Register access uses a simple word-addressed write port and a combinational read port. All bus timing is derived from the system clock: each SCLK half period lasts `HALF_DIV` clock cycles.

Top module: `spi_cmd_shifter`

## Requirements
- R1: Register word addresses are: 0 command, 1 bit count, 2 status result, 3 enable key, 4 to 9 transmit bytes 0 to 5, 10 to 15 capture bytes 0 to 5; after reset chip select is high, SCLK is low and the command and status registers read 0.
- R2: A start code is accepted only while the last value written to the enable key register was 0x30; otherwise the write has no effect and no transfer begins.
- R3: Code 0x04 sends min(count, 56) bits of the 56-bit stream made of transmit byte 5 (opcode) down to transmit byte 0 and then one zero byte, MSB first; SCLK idles low, MOSI changes after falling edges, chip select is low from before the first rising edge until after the last falling edge, and the SCLK period is 2*HALF_DIV clock cycles.
- R4: The command register reads back the running start code (0x02, 0x04 or 0x20) from the cycle after the start write until the transfer ends, and 0 afterwards.
- R5: MISO is sampled on each rising SCLK edge into a capture chain cleared at start; capture byte k holds received bits 8k+7..8k counted back from the last bit, so with N receive bytes after the opcode the first one sits in capture byte N-1 and the last in capture byte 0.
- R6: Code 0x02 sends opcode 0x05 then 8 further bits (16 bits total, count register not used) and stores the last 8 received bits in the status result register.
- R7: Code 0x20 sends opcode 0x01 then transmit byte 5 (16 bits total, count register not used); the status result register is unchanged.
- R8: A start code written while a transfer runs is ignored: the running transfer and its readback code are unaffected and no extra transfer follows.
- R9: Code 0x04 with a count of 0 completes at once: the command register reads 0 on the next cycle and chip select stays high.
- R10: Any command value other than 0x02, 0x04 and 0x20 starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register write word address |
| wrData | input | 8 | Register write data |
| rdAddr | input | 4 | Register read word address |
| rdData | output | 8 | Register read data (combinational) |
| spiCsN | output | 1 | Active-low chip select |
| spiSclk | output | 1 | Serial clock, idles low |
| spiMosi | output | 1 | Serial data toward the device |
| spiMiso | input | 1 | Serial data from the device |

## Verification
The bench aims at the length corners: a full 56-bit transfer whose last byte must be zero, a count above 56 that must clamp, a count of 12 that is not a whole byte, and a count of zero that must never pull chip select low; a design that mishandled these would send extra or missing bits, or a spurious select pulse that the scoreboard flags as an unexpected transfer. It checks the capture order by feeding a distinct byte per position, so a reversed or shifted bank shows as wrong bytes at indices 0 to 3. It writes start codes while locked, after relocking, with an unknown value and during a running transfer, where a design that failed to ignore them would produce a transfer the scoreboard never ordered or a changed readback code. The status shortcuts are checked for their fixed opcodes and for touching the result register only on a read.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  // Number of software-loaded transmit bytes; one extra zero byte follows them.
  localparam int PRG_BYTES = 6;
  localparam int MAX_BITS  = 8 * (PRG_BYTES + 1);
  localparam int BITS_W    = $clog2(MAX_BITS + 1);
  localparam int ADDR_W    = 4;

  localparam logic [ADDR_W-1:0] A_CMD  = 4'd0;
  localparam logic [ADDR_W-1:0] A_CNT  = 4'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd2;
  localparam logic [ADDR_W-1:0] A_KEY  = 4'd3;
  localparam logic [ADDR_W-1:0] A_PRG0 = 4'd4;
  localparam logic [ADDR_W-1:0] A_CAP0 = 4'd10;

  typedef enum logic [7:0] {
    OP_IDLE = 8'h00,
    OP_RDSR = 8'h02,
    OP_XFER = 8'h04,
    OP_WRSR = 8'h20
  } op_e;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic load;
    op_e  loadOp;
    logic sample;
    logic advance;
    logic latchStatus;
  } strobe_t;

endpackage

// File: rtl/spi_cmd_datapath.sv
module spi_cmd_datapath
  import spi_cmd_pkg::*;
#(
  parameter logic [7:0] RDSR_OPCODE = 8'h05,
  parameter logic [7:0] WRSR_OPCODE = 8'h01,
  parameter logic [7:0] UNLOCK_KEY  = 8'h30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  input  logic              miso,
  output logic              mosi,
  input  strobe_t           strb,
  input  op_e               curOp,
  output logic              startReq,
  output op_e               reqOp,
  output logic [BITS_W-1:0] reqBits
);

  localparam logic [7:0]        MAX_CNT   = 8'(MAX_BITS);
  localparam logic [BITS_W-1:0] SHORT_LEN = BITS_W'(16);
  localparam int                PAD_RDSR  = MAX_BITS - 8;
  localparam int                PAD_WRSR  = MAX_BITS - 16;

  logic [7:0]          prgBank [PRG_BYTES];
  logic [7:0]          countReg;
  logic [7:0]          statusReg;
  logic                unlocked;
  logic [MAX_BITS-1:0] txShift;
  logic [MAX_BITS-1:0] rxShift;
  logic [MAX_BITS-1:0] bankVec;
  logic [MAX_BITS-1:0] loadVec;
  logic                legalCode;

  // ---------------- register writes ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countReg <= '0;
      unlocked <= 1'b0;
      for (int i = 0; i < PRG_BYTES; i++) prgBank[i] <= '0;
    end else if (wrEn) begin
      if (wrAddr == A_CNT) countReg <= wrData;
      if (wrAddr == A_KEY) unlocked <= (wrData == UNLOCK_KEY);
      for (int i = 0; i < PRG_BYTES; i++) begin
        if (wrAddr == A_PRG0 + ADDR_W'(i)) prgBank[i] <= wrData;
      end
    end
  end

  // ---------------- start decode ----------------
  always_comb begin
    legalCode = (wrData == OP_RDSR) || (wrData == OP_XFER) || (wrData == OP_WRSR);
    startReq  = wrEn && (wrAddr == A_CMD) && unlocked && legalCode;
    reqOp     = legalCode ? op_e'(wrData) : OP_IDLE;
    if (reqOp == OP_XFER) begin
      reqBits = (countReg > MAX_CNT) ? BITS_W'(MAX_BITS) : countReg[BITS_W-1:0];
    end else begin
      reqBits = SHORT_LEN;
    end
  end

  // ---------------- outgoing stream ----------------
  generate
    for (genvar g = 0; g < PRG_BYTES; g++) begin : g_bank
      assign bankVec[8*(g+1) +: 8] = prgBank[g];
    end
  endgenerate
  assign bankVec[7:0] = 8'h00;

  always_comb begin
    unique case (strb.loadOp)
      OP_RDSR: loadVec = {RDSR_OPCODE, {PAD_RDSR{1'b0}}};
      OP_WRSR: loadVec = {WRSR_OPCODE, prgBank[PRG_BYTES-1], {PAD_WRSR{1'b0}}};
      default: loadVec = bankVec;
    endcase
  end

  // ---------------- shift chains ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift   <= '0;
      rxShift   <= '0;
      statusReg <= '0;
    end else begin
      if (strb.load) begin
        txShift <= loadVec;
        rxShift <= '0;
      end else begin
        if (strb.advance) txShift <= {txShift[MAX_BITS-2:0], 1'b0};
        if (strb.sample)  rxShift <= {rxShift[MAX_BITS-2:0], miso};
      end
      if (strb.latchStatus) statusReg <= rxShift[7:0];
    end
  end

  assign mosi = txShift[MAX_BITS-1];

  // ---------------- register reads ----------------
  always_comb begin
    rdData = '0;
    if (rdAddr == A_CMD)  rdData = curOp;
    if (rdAddr == A_CNT)  rdData = countReg;
    if (rdAddr == A_STAT) rdData = statusReg;
    if (rdAddr == A_KEY)  rdData = {7'd0, unlocked};
    for (int i = 0; i < PRG_BYTES; i++) begin
      if (rdAddr == A_PRG0 + ADDR_W'(i)) rdData = prgBank[i];
      if (rdAddr == A_CAP0 + ADDR_W'(i)) rdData = rxShift[8*i +: 8];
    end
  end

  // ---------------- assertions ----------------
  assert_load_needs_key_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> unlocked);

  assert_status_only_on_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(statusReg) |-> $past(strb.latchStatus));

  assert_no_load_from_bad_code_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> (strb.loadOp != OP_IDLE));

endmodule

// File: rtl/spi_cmd_control.sv
module spi_cmd_control
  import spi_cmd_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  op_e               reqOp,
  input  logic [BITS_W-1:0] reqBits,
  output strobe_t           strb,
  output op_e               curOp,
  output logic              csN,
  output logic              sclk
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} state_e;

  state_e            state;
  logic [DIV_W-1:0]  divCnt;
  logic [BITS_W-1:0] bitCnt;
  logic [BITS_W-1:0] totBits;
  logic              divEnd;
  logic              lastBit;
  logic              finishing;
  logic              startGo;

  always_comb begin
    divEnd    = (divCnt == DIV_LAST);
    lastBit   = (bitCnt == BITS_W'(totBits - 1'b1));
    finishing = (state == ST_HIGH) && divEnd && lastBit;
    startGo   = (state == ST_IDLE) && startReq && (reqBits != '0);

    strb             = '0;
    strb.loadOp      = reqOp;
    strb.load        = startGo;
    strb.sample      = (state == ST_LOW) && divEnd;
    strb.advance     = (state == ST_HIGH) && divEnd && !lastBit;
    strb.latchStatus = finishing && (curOp == OP_RDSR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      bitCnt  <= '0;
      totBits <= '0;
      curOp   <= OP_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startGo) begin
            state   <= ST_LOW;
            divCnt  <= '0;
            bitCnt  <= '0;
            totBits <= reqBits;
            curOp   <= reqOp;
          end
        end
        ST_LOW: begin
          if (divEnd) begin
            divCnt <= '0;
            state  <= ST_HIGH;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_HIGH: begin
          if (divEnd) begin
            divCnt <= '0;
            if (lastBit) begin
              state <= ST_IDLE;
              curOp <= OP_IDLE;
            end else begin
              bitCnt <= bitCnt + 1'b1;
              state  <= ST_LOW;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign csN  = (state == ST_IDLE);
  assign sclk = (state == ST_HIGH);

  // ---------------- assertions ----------------
  assert_zero_count_no_select_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_IDLE) && startReq && (reqBits == '0)) |=> csN);

  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((state != ST_IDLE) && startReq && !finishing) |=> $stable(curOp) && $stable(totBits));

  assert_bit_in_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> (bitCnt < totBits) && (totBits <= BITS_W'(MAX_BITS)));

  assert_busy_code_shown_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> (curOp != OP_IDLE));

endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
  import spi_cmd_pkg::*;
#(
  parameter int         HALF_DIV    = 2,
  parameter logic [7:0] RDSR_OPCODE = 8'h05,
  parameter logic [7:0] WRSR_OPCODE = 8'h01,
  parameter logic [7:0] UNLOCK_KEY  = 8'h30
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [3:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic [3:0] rdAddr,
  output logic [7:0] rdData,
  output logic       spiCsN,
  output logic       spiSclk,
  output logic       spiMosi,
  input  logic       spiMiso
);

  strobe_t           strb;
  op_e               curOp;
  op_e               reqOp;
  logic              startReq;
  logic [BITS_W-1:0] reqBits;

  spi_cmd_datapath #(
    .RDSR_OPCODE(RDSR_OPCODE),
    .WRSR_OPCODE(WRSR_OPCODE),
    .UNLOCK_KEY (UNLOCK_KEY)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .rdAddr  (rdAddr),
    .rdData  (rdData),
    .miso    (spiMiso),
    .mosi    (spiMosi),
    .strb    (strb),
    .curOp   (curOp),
    .startReq(startReq),
    .reqOp   (reqOp),
    .reqBits (reqBits)
  );

  spi_cmd_control #(
    .HALF_DIV(HALF_DIV)
  ) u_control (
    .clk     (clk),
    .rstN    (rstN),
    .startReq(startReq),
    .reqOp   (reqOp),
    .reqBits (reqBits),
    .strb    (strb),
    .curOp   (curOp),
    .csN     (spiCsN),
    .sclk    (spiSclk)
  );

endmodule

// File: tb/spi_cmd_shifter_bench.sv
`timescale 1ns/100ps
module spi_cmd_shifter_bench;

  localparam int HALF = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [3:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       csN, sclk, mosi;
  logic       miso = 1'b0;

  spi_cmd_shifter #(.HALF_DIV(HALF)) u_spi_cmd_shifter (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .spiCsN(csN), .spiSclk(sclk),
    .spiMosi(mosi), .spiMiso(miso)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // ---------------- scoreboard ----------------
  typedef struct { int nbits; logic [55:0] vec; string tag; } exp_t;
  exp_t expQ[$];
  bit   armed = 1'b0;

  logic [55:0] gotV;
  int          gotN;
  realtime     firstRise;

  always @(negedge csN) if (armed) begin
    gotV = '0;
    gotN = 0;
    check(sclk == 1'b0, "R3", "sclk low at select", {63'd0, sclk}, 64'd0);
  end

  always @(posedge sclk) if (armed && !csN) begin
    gotV = {gotV[54:0], mosi};
    gotN++;
    if (gotN == 1) firstRise = $realtime;
    if (gotN == 2)
      check(($realtime - firstRise) == 2.0 * HALF * 5.0, "R3", "sclk period",
            64'($rtoi($realtime - firstRise)), 64'(2 * HALF * 5));
  end

  always @(posedge csN) if (armed) begin
    if (expQ.size() == 0) begin
      check(1'b0, "R8", "unexpected transfer", 64'(gotN), 64'd0);
    end else begin
      exp_t e;
      e = expQ.pop_front();
      check(gotN == e.nbits, e.tag, "bit count", 64'(gotN), 64'(e.nbits));
      check(gotV == e.vec, e.tag, "mosi stream", {8'd0, gotV}, {8'd0, e.vec});
    end
  end

  // ---------------- device model ----------------
  logic [55:0] respVec = '0;
  logic [55:0] slaveSh;
  always @(negedge csN) begin slaveSh = respVec; miso = slaveSh[55]; end
  always @(negedge sclk) if (!csN) begin slaveSh = {slaveSh[54:0], 1'b0}; miso = slaveSh[55]; end

  // ---------------- driver ----------------
  logic [7:0] pd [6];

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic setPd(input logic [47:0] v);
    for (int i = 0; i < 6; i++) begin
      pd[i] = v[8*i +: 8];
      wr(4'(4 + i), pd[i]);
    end
  endtask

  task automatic pushXfer(input int nbits, input logic [55:0] full, input string tag);
    exp_t e;
    e.nbits = nbits;
    e.vec   = (nbits == 0) ? 56'd0 : (full >> (56 - nbits));
    e.tag   = tag;
    expQ.push_back(e);
  endtask

  function automatic logic [55:0] bankStream();
    return {pd[5], pd[4], pd[3], pd[2], pd[1], pd[0], 8'h00};
  endfunction

  task automatic waitDone();
    logic [7:0] v;
    for (int i = 0; i < 4000; i++) begin
      rd(4'd0, v);
      if (v == 8'h00) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic checkCapture(input int nbits, input string tag);
    logic [55:0] stream;
    logic [7:0]  v;
    stream = respVec >> (56 - nbits);
    for (int k = 0; k < 6; k++) begin
      rd(4'(10 + k), v);
      check(v == stream[8*k +: 8], tag, $sformatf("capture byte %0d", k), 64'(v), 64'(stream[8*k +: 8]));
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    int         idleOk;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    armed = 1'b1;

    // R1: reset state
    check(csN == 1'b1 && sclk == 1'b0, "R1", "idle pins", {62'd0, csN, sclk}, 64'd2);
    rd(4'd0, v); check(v == 8'h00, "R1", "command after reset", 64'(v), 64'd0);
    rd(4'd2, v); check(v == 8'h00, "R1", "status after reset", 64'(v), 64'd0);

    // R2: locked controller ignores start
    setPd(48'h9F_00_00_00_00_00);
    wr(4'd1, 8'd32);
    wr(4'd0, 8'h04);
    rd(4'd0, v); check(v == 8'h00, "R2", "locked start readback", 64'(v), 64'd0);
    idleOk = 1;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (!csN) idleOk = 0; end
    check(idleOk == 1, "R2", "locked select stays high", 64'(idleOk), 64'd1);

    // unlock; R3/R4/R5: opcode plus three receive bytes
    wr(4'd3, 8'h30);
    respVec = 56'hAA_BB_CC_DD_EE_F1_F2;
    pushXfer(32, bankStream(), "R3");
    wr(4'd0, 8'h04);
    rd(4'd0, v); check(v == 8'h04, "R4", "busy readback", 64'(v), 64'h04);
    waitDone();
    rd(4'd0, v); check(v == 8'h00, "R4", "done readback", 64'(v), 64'd0);
    checkCapture(32, "R5");

    // R3: full 56-bit stream with trailing zero byte
    setPd(48'h06_11_22_33_44_55);
    respVec = 56'h01_02_03_04_05_06_07;
    wr(4'd1, 8'd56);
    pushXfer(56, bankStream(), "R3");
    wr(4'd0, 8'h04);
    waitDone();
    checkCapture(56, "R5");

    // R3: count above limit clamps to 56
    setPd(48'hA5_5A_C3_3C_0F_F0);
    wr(4'd1, 8'd80);
    pushXfer(56, bankStream(), "R3");
    wr(4'd0, 8'h04);
    waitDone();

    // R3/R5: count of 12 bits, not byte aligned
    respVec = 56'hB7_E4_00_00_00_00_00;
    wr(4'd1, 8'd12);
    pushXfer(12, bankStream(), "R3");
    wr(4'd0, 8'h04);
    waitDone();
    checkCapture(12, "R5");

    // R6: read status shortcut
    respVec = 56'hFF_5A_00_00_00_00_00;
    pushXfer(16, 56'h05_00_00_00_00_00_00, "R6");
    wr(4'd0, 8'h02);
    rd(4'd0, v); check(v == 8'h02, "R4", "status read busy code", 64'(v), 64'h02);
    waitDone();
    rd(4'd2, v); check(v == 8'h5A, "R6", "status result", 64'(v), 64'h5A);

    // R7: write status shortcut, count register ignored, result untouched
    wr(4'd5 + 4'd4, 8'hC3);
    wr(4'd1, 8'd40);
    respVec = 56'h12_34_00_00_00_00_00;
    pushXfer(16, 56'h01_C3_00_00_00_00_00, "R7");
    wr(4'd0, 8'h20);
    rd(4'd0, v); check(v == 8'h20, "R4", "status write busy code", 64'(v), 64'h20);
    waitDone();
    rd(4'd2, v); check(v == 8'h5A, "R7", "status result kept", 64'(v), 64'h5A);

    // R8: start during a running transfer
    setPd(48'h9F_00_00_00_00_00);
    wr(4'd1, 8'd32);
    pushXfer(32, bankStream(), "R8");
    wr(4'd0, 8'h04);
    repeat (5) @(negedge clk);
    wr(4'd0, 8'h02);
    rd(4'd0, v); check(v == 8'h04, "R8", "readback after busy start", 64'(v), 64'h04);
    waitDone();
    rd(4'd2, v); check(v == 8'h5A, "R8", "status untouched", 64'(v), 64'h5A);

    // R9: zero count
    wr(4'd1, 8'd0);
    wr(4'd0, 8'h04);
    rd(4'd0, v); check(v == 8'h00, "R9", "zero count readback", 64'(v), 64'd0);
    idleOk = 1;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (!csN) idleOk = 0; end
    check(idleOk == 1, "R9", "zero count select high", 64'(idleOk), 64'd1);

    // R10: unknown command code
    wr(4'd1, 8'd16);
    wr(4'd0, 8'h10);
    rd(4'd0, v); check(v == 8'h00, "R10", "unknown code readback", 64'(v), 64'd0);
    idleOk = 1;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (!csN) idleOk = 0; end
    check(idleOk == 1, "R10", "unknown code select high", 64'(idleOk), 64'd1);

    // R2: relock with a different key value
    wr(4'd3, 8'h31);
    wr(4'd0, 8'h04);
    rd(4'd0, v); check(v == 8'h00, "R2", "relocked readback", 64'(v), 64'd0);
    idleOk = 1;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (!csN) idleOk = 0; end
    check(idleOk == 1, "R2", "relocked select high", 64'(idleOk), 64'd1);

    check(expQ.size() == 0, "R8", "scoreboard drained", 64'(expQ.size()), 64'd0);
    summary();
    $finish;
  end

endmodule